// File: doc/BRIEF.md
# Serial Port FIFO Control with Request Triggers

This block sits beside the shifter of a serial port and owns its two byte queues: one carrying bytes toward the line (transmit) and one carrying received bytes toward the system (receive). Each queue has push and pop ports, a byte count and empty and full flags. A single 32-bit control word, written and read over a simple register port, selects a fill threshold for each queue. From that threshold the block raises a receive request when enough bytes are waiting, and a transmit request when enough free room exists. An interrupt or DMA engine consumes these requests.

The same word carries two kinds of reset. A port reset bit clears the rest of the port logic for a fixed number of cycles and then clears itself. The queues keep their contents through it. Two queue-flush bits empty the transmit or receive queue. They act only while a separate flush-enable bit is also set, and they hold the queue empty until software writes them back to zero.

Top module: `sfc_top`

## Requirements
- R1: After reset the control word reads 0, both queues are empty with count 0, rx_req, tx_lvl_err and port_rst_busy are low, and tx_req is high (16 free slots, threshold 1).
- R2: Control word fields are receive threshold code at bits 8:7, transmit threshold code at bits 4:3, transmit flush at bit 2, receive flush at bit 1 and flush enable at bit 0; they read back as written, and bits 31:16, 14:9 and 6:5 ignore writes and read 0.
- R3: Writing 1 to bit 15 starts a port reset: bit 15 reads 1 while it runs, all other fields return to 0, control writes during the run are ignored, and queue contents and counts are kept.
- R4: rx_req is high exactly when the receive count is at least the threshold of the receive code: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 12 bytes.
- R5: tx_req is high exactly when the free slots (16 minus the transmit count) are at least the threshold of the transmit code: 00 gives 1, 01 gives 4, 10 gives 8 slots.
- R6: With transmit code 11, tx_req stays low and tx_lvl_err is high.
- R7: A flush bit acts only while bit 0 is 1; while held, that queue shows count 0, empty 1, full 0, its request low, and pushes and pops to it are ignored.
- R8: A flush is not self-clearing: the bit reads back 1 and the queue stays empty until software writes it to 0, after which the queue works from empty.
- R9: Each queue is first-in first-out, pop data shows the oldest byte, and a push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged.
- R10: Each queue holds 16 bytes; full is high at 16, a push while full and a pop while empty are ignored.
- R11: port_rst_busy is high for exactly 4 cycles, starting in the cycle after the port reset write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| port_rst_busy | output | 1 | Port reset in progress, drives the rest of the port |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_push_data | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Pop the oldest transmit byte |
| tx_pop_data | output | 8 | Oldest transmit byte |
| tx_count | output | 5 | Transmit queue occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_push_data | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Pop the oldest receive byte |
| rx_pop_data | output | 8 | Oldest receive byte |
| rx_count | output | 5 | Receive queue occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_req | output | 1 | Transmit room request |
| rx_req | output | 1 | Receive data request |
| tx_lvl_err | output | 1 | Illegal transmit threshold code programmed |

## Verification
A push and a pop can hit the same queue in the same cycle, and the count must then stay put while the popped byte is still the oldest one. The bench drives both strobes for one cycle on a receive queue holding two bytes. A scoreboard queue judges the popped byte, and the count is compared before and after. A control write can also fall inside a running port reset. The bench issues one there and expects the control word to read all zeros once the busy window closes.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  // Control word bit positions (software relies on these)
  localparam int unsigned BIT_FLUSH_EN = 0;
  localparam int unsigned BIT_RX_FLUSH = 1;
  localparam int unsigned BIT_TX_FLUSH = 2;
  localparam int unsigned TX_CODE_LO   = 3;
  localparam int unsigned RX_CODE_LO   = 7;
  localparam int unsigned BIT_PORT_RST = 15;

  typedef struct packed {
    logic [1:0] rx_code;
    logic [1:0] tx_code;
    logic       tx_flush;
    logic       rx_flush;
    logic       flush_en;
  } ctl_t;

  // Receive threshold in bytes for a 2-bit code
  function automatic int unsigned rx_thresh(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 12;
    endcase
  endfunction

  // Transmit threshold in free slots; code 3 is illegal (returns 0)
  function automatic int unsigned tx_thresh(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sfc_ctrl_reg.sv
module sfc_ctrl_reg
  import sfc_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        busy,
  output logic [1:0]  rx_code,
  output logic [1:0]  tx_code,
  output logic        tx_flush_act,
  output logic        rx_flush_act
);

  localparam int unsigned CNTW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

  ctl_t            ctl_q, ctl_d;
  logic            busy_q, busy_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  logic unused_rsvd;
  assign unused_rsvd = ^{wdata[31:16], wdata[14:9], wdata[6:5]};

  always_comb begin
    ctl_d  = ctl_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      ctl_d = '0;
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (wr) begin
      if (wdata[BIT_PORT_RST]) begin
        busy_d = 1'b1;
        cnt_d  = CNTW'(RST_CYCLES - 1);
        ctl_d  = '0;
      end else begin
        ctl_d.rx_code  = wdata[RX_CODE_LO +: 2];
        ctl_d.tx_code  = wdata[TX_CODE_LO +: 2];
        ctl_d.tx_flush = wdata[BIT_TX_FLUSH];
        ctl_d.rx_flush = wdata[BIT_RX_FLUSH];
        ctl_d.flush_en = wdata[BIT_FLUSH_EN];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ctl_q  <= ctl_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    rdata                   = '0;
    rdata[BIT_PORT_RST]     = busy_q;
    rdata[RX_CODE_LO +: 2]  = ctl_q.rx_code;
    rdata[TX_CODE_LO +: 2]  = ctl_q.tx_code;
    rdata[BIT_TX_FLUSH]     = ctl_q.tx_flush;
    rdata[BIT_RX_FLUSH]     = ctl_q.rx_flush;
    rdata[BIT_FLUSH_EN]     = ctl_q.flush_en;
  end

  assign busy         = busy_q;
  assign rx_code      = ctl_q.rx_code;
  assign tx_code      = ctl_q.tx_code;
  assign tx_flush_act = ctl_q.flush_en & ctl_q.tx_flush;
  assign rx_flush_act = ctl_q.flush_en & ctl_q.rx_flush;

endmodule

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;
  logic          is_empty, is_full;

  assign is_empty = flush | (cnt_q == '0);
  assign is_full  = ~flush & (cnt_q == CW'(DEPTH));
  assign push_ok  = push & ~is_full & ~flush;
  assign pop_ok   = pop & ~is_empty;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = step(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = step(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage: no reset, written under its own enable
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_data;
  end

  assign pop_data = mem[rd_ptr_q];
  assign count    = flush ? '0 : cnt_q;
  assign empty    = is_empty;
  assign full     = is_full;

endmodule

// File: rtl/sfc_trigger.sv
module sfc_trigger
  import sfc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic [1:0]    rx_code,
  input  logic [1:0]    tx_code,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          rx_flush,
  input  logic          tx_flush,
  output logic          rx_req,
  output logic          tx_req,
  output logic          tx_lvl_err
);

  logic [CW-1:0] rx_lvl, tx_lvl, tx_free;

  assign rx_lvl     = CW'(rx_thresh(rx_code));
  assign tx_lvl     = CW'(tx_thresh(tx_code));
  assign tx_free    = CW'(DEPTH) - tx_count;
  assign tx_lvl_err = (tx_code == 2'b11);

  assign rx_req = ~rx_flush & (rx_count >= rx_lvl);
  assign tx_req = ~tx_flush & ~tx_lvl_err & (tx_free >= tx_lvl);

endmodule

// File: rtl/sfc_top.sv
module sfc_top #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              port_rst_busy,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_push_data,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_pop_data,
  output logic [CW-1:0]     tx_count,
  output logic              tx_empty,
  output logic              tx_full,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_push_data,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_pop_data,
  output logic [CW-1:0]     rx_count,
  output logic              rx_empty,
  output logic              rx_full,
  output logic              tx_req,
  output logic              rx_req,
  output logic              tx_lvl_err
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [1:0] rx_code, tx_code;
  logic       tx_flush, rx_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sfc_ctrl_reg #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .wr           (reg_wr),
    .wdata        (reg_wdata),
    .rdata        (reg_rdata),
    .busy         (port_rst_busy),
    .rx_code      (rx_code),
    .tx_code      (tx_code),
    .tx_flush_act (tx_flush),
    .rx_flush_act (rx_flush)
  );

  for (genvar g = 0; g < 2; g++) begin : g_q
    if (g == 0) begin : g_tx
      sfc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_int_n), .flush(tx_flush),
        .push(tx_push), .push_data(tx_push_data),
        .pop(tx_pop), .pop_data(tx_pop_data),
        .count(tx_count), .empty(tx_empty), .full(tx_full)
      );
    end else begin : g_rx
      sfc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_int_n), .flush(rx_flush),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rx_pop), .pop_data(rx_pop_data),
        .count(rx_count), .empty(rx_empty), .full(rx_full)
      );
    end
  end

  sfc_trigger #(.DEPTH(DEPTH)) u_trig (
    .rx_code    (rx_code),
    .tx_code    (tx_code),
    .rx_count   (rx_count),
    .tx_count   (tx_count),
    .rx_flush   (rx_flush),
    .tx_flush   (tx_flush),
    .rx_req     (rx_req),
    .tx_req     (tx_req),
    .tx_lvl_err (tx_lvl_err)
  );

endmodule

// File: rtl/sfc_chk.sv
module sfc_chk #(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   reg_rdata,
  input logic          port_rst_busy,
  input logic          tx_req,
  input logic          tx_lvl_err,
  input logic [CW-1:0] tx_count,
  input logic          tx_empty,
  input logic          tx_full,
  input logic          rx_req,
  input logic [CW-1:0] rx_count,
  input logic          rx_empty,
  input logic          rx_full
);

  logic [7:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_run_q <= '0;
    else if (!port_rst_busy)   busy_run_q <= '0;
    else if (busy_run_q != 8'hFF) busy_run_q <= busy_run_q + 8'd1;
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 32'hFFFF_7E60) == 32'h0);

  // R3
  port_rst_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst_busy |-> (reg_rdata[15] && reg_rdata[8:0] == 9'h0));

  // R11
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run_q <= 8'(RST_CYCLES));

  // R6
  tx_code_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[4:3] == 2'b11) |-> (tx_lvl_err && !tx_req));

  // R7
  tx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && reg_rdata[2]) |-> (tx_empty && !tx_full && tx_count == '0 && !tx_req));

  // R7
  rx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && reg_rdata[1]) |-> (rx_empty && !rx_full && rx_count == '0 && !rx_req));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH))
    && (tx_full == (tx_count == CW'(DEPTH))) && (rx_full == (rx_count == CW'(DEPTH))));

  // R4
  rx_req_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> !rx_empty);

endmodule

bind sfc_top sfc_chk #(.DEPTH(DEPTH), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_rdata     (reg_rdata),
  .port_rst_busy (port_rst_busy),
  .tx_req        (tx_req),
  .tx_lvl_err    (tx_lvl_err),
  .tx_count      (tx_count),
  .tx_empty      (tx_empty),
  .tx_full       (tx_full),
  .rx_req        (rx_req),
  .rx_count      (rx_count),
  .rx_empty      (rx_empty),
  .rx_full       (rx_full)
);

// File: tb/sfc_top_test.sv
`timescale 1ns/1ps
module sfc_top_test;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        port_rst_busy;
  logic        tx_push, tx_pop, rx_push, rx_pop;
  logic [7:0]  tx_push_data, rx_push_data, tx_pop_data, rx_pop_data;
  logic [4:0]  tx_count, rx_count;
  logic        tx_empty, tx_full, rx_empty, rx_full;
  logic        tx_req, rx_req, tx_lvl_err;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #10 clk = ~clk;

  sfc_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .port_rst_busy(port_rst_busy),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
    .tx_pop_data(tx_pop_data), .tx_count(tx_count), .tx_empty(tx_empty),
    .tx_full(tx_full), .rx_push(rx_push), .rx_push_data(rx_push_data),
    .rx_pop(rx_pop), .rx_pop_data(rx_pop_data), .rx_count(rx_count),
    .rx_empty(rx_empty), .rx_full(rx_full), .tx_req(tx_req),
    .rx_req(rx_req), .tx_lvl_err(tx_lvl_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wr(logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic push_tx(logic [7:0] d);
    @(posedge clk); #2;
    tx_push = 1'b1; tx_push_data = d;
    if (txq.size() < DEPTH) txq.push_back(d);
    @(posedge clk); #2;
    tx_push = 1'b0;
  endtask

  task automatic push_rx(logic [7:0] d, bit stored);
    @(posedge clk); #2;
    rx_push = 1'b1; rx_push_data = d;
    if (stored && rxq.size() < DEPTH) rxq.push_back(d);
    @(posedge clk); #2;
    rx_push = 1'b0;
  endtask

  task automatic pop_tx();
    @(posedge clk); #2; tx_pop = 1'b1;
    @(posedge clk); #2; tx_pop = 1'b0;
  endtask

  task automatic pop_rx();
    @(posedge clk); #2; rx_pop = 1'b1;
    @(posedge clk); #2; rx_pop = 1'b0;
  endtask

  // Monitor: compares popped bytes against the scoreboard (R9)
  always @(negedge clk) begin
    if (rst_n && tx_pop && !tx_empty) begin
      if (txq.size() == 0) check("R9 tx unexpected pop", {24'h0, tx_pop_data}, 32'hFFFF_FFFF);
      else begin check("R9 tx order", {24'h0, tx_pop_data}, {24'h0, txq[0]}); void'(txq.pop_front()); end
    end
    if (rst_n && rx_pop && !rx_empty) begin
      if (rxq.size() == 0) check("R9 rx unexpected pop", {24'h0, rx_pop_data}, 32'hFFFF_FFFF);
      else begin check("R9 rx order", {24'h0, rx_pop_data}, {24'h0, rxq[0]}); void'(rxq.pop_front()); end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    int lv[4] = '{1, 4, 8, 12};
    int nbusy;
    logic [4:0] c0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    tx_push_data = '0; rx_push_data = '0;
    repeat (3) @(posedge clk); #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 counts", {tx_count, rx_count}, 10'h0);
    check("R1 empties", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    check("R1 req/err/busy", {tx_req, rx_req, tx_lvl_err, port_rst_busy}, 4'b1000);

    // R2 field readback, reserved bits dropped
    wr(32'hFFFF_7FF0); @(negedge clk);
    check("R2 readback", reg_rdata, 32'h0000_0190);

    // R5 transmit threshold code 10 (8 free slots)
    for (int i = 0; i < 9; i++) begin
      push_tx(8'h10 + 8'(i)); @(negedge clk);
      if (i == 7) check("R5 free8 code10", {31'h0, tx_req}, 1);
      if (i == 8) check("R5 free7 code10", {31'h0, tx_req}, 0);
    end
    wr(32'h0000_0008); @(negedge clk);
    check("R5 free7 code01", {31'h0, tx_req}, 1);
    for (int i = 0; i < 4; i++) begin
      push_tx(8'h20 + 8'(i)); @(negedge clk);
      if (i == 2) check("R5 free4 code01", {31'h0, tx_req}, 1);
      if (i == 3) check("R5 free3 code01", {31'h0, tx_req}, 0);
    end
    wr(32'h0); @(negedge clk);
    check("R5 free3 code00", {31'h0, tx_req}, 1);
    for (int i = 0; i < 3; i++) push_tx(8'h30 + 8'(i));
    @(negedge clk);
    check("R10 full", {27'h0, tx_count, tx_full}, {27'h0, 5'd16, 1'b1});
    check("R5 free0", {31'h0, tx_req}, 0);
    push_tx(8'hEE); @(negedge clk);
    check("R10 push when full", {27'h0, tx_count}, 16);

    // R9 drain transmit queue in order
    for (int i = 0; i < 16; i++) pop_tx();
    @(negedge clk);
    check("R9 tx drained", {26'h0, tx_count, tx_empty}, {26'h0, 5'd0, 1'b1});
    pop_tx(); @(negedge clk);
    check("R10 pop when empty", {27'h0, tx_count}, 0);

    // R6 illegal transmit code
    wr(32'h0000_0018); @(negedge clk);
    check("R6 err/req", {30'h0, tx_lvl_err, tx_req}, 2'b10);
    wr(32'h0);

    // R4 receive thresholds, each followed by an enabled flush
    for (int c = 0; c < 4; c++) begin
      wr(32'(c) << 7);
      for (int i = 0; i < lv[c]; i++) begin
        @(negedge clk);
        if (i == lv[c] - 1) check($sformatf("R4 below code%0d", c), {31'h0, rx_req}, 0);
        push_rx(8'h40 + 8'(i), 1'b1);
      end
      @(negedge clk);
      check($sformatf("R4 at code%0d", c), {31'h0, rx_req}, 1);
      wr((32'(c) << 7) | 32'h3); rxq.delete();
      @(negedge clk);
      check("R7 rx flushed", {26'h0, rx_count, rx_empty}, {26'h0, 5'd0, 1'b1});
      wr(32'h0);
    end

    // R7 flush without enable has no effect
    for (int i = 0; i < 3; i++) push_rx(8'h50 + 8'(i), 1'b1);
    wr(32'h0000_0002); @(negedge clk);
    check("R7 no enable", {27'h0, rx_count}, 3);
    wr(32'h0000_0003); rxq.delete(); @(negedge clk);
    check("R7 enabled flush", {26'h0, rx_count, rx_empty}, {26'h0, 5'd0, 1'b1});
    push_rx(8'h66, 1'b0); pop_rx(); @(negedge clk);
    check("R7 push ignored", {27'h0, rx_count}, 0);
    repeat (5) @(posedge clk); @(negedge clk);
    // R8 flush held until cleared
    check("R8 bit held", reg_rdata, 32'h3);
    check("R8 still empty", {31'h0, rx_empty}, 1);
    wr(32'h0); @(negedge clk);
    check("R8 released empty", {26'h0, rx_count, rx_empty}, {26'h0, 5'd0, 1'b1});
    push_rx(8'hA1, 1'b1); push_rx(8'hA2, 1'b1); @(negedge clk);
    check("R8 works after release", {27'h0, rx_count}, 2);

    // R9 push and pop in one cycle
    c0 = rx_count;
    @(posedge clk); #2;
    rx_push = 1'b1; rx_push_data = 8'hA3; rx_pop = 1'b1; rxq.push_back(8'hA3);
    @(posedge clk); #2; rx_push = 1'b0; rx_pop = 1'b0;
    @(negedge clk);
    check("R9 same-cycle count", {27'h0, rx_count}, {27'h0, c0});

    // R3 / R11 port reset
    push_tx(8'h77);
    wr(32'h0000_0190); wr(32'h0000_8190);
    @(negedge clk);
    check("R3 fields cleared", reg_rdata, 32'h0000_8000);
    nbusy = 0;
    while (port_rst_busy && nbusy < 20) begin nbusy++; @(negedge clk); end
    check("R11 busy cycles", nbusy, 4);
    check("R3 self-cleared", reg_rdata, 32'h0);
    wr(32'h0000_8000); wr(32'h0000_0190);
    repeat (6) @(posedge clk); @(negedge clk);
    check("R3 write during reset ignored", reg_rdata, 32'h0);
    check("R3 queues kept", {22'h0, tx_count, rx_count}, {22'h0, 5'd1, 5'd2});
    pop_tx(); pop_rx(); pop_rx();
    @(negedge clk);
    check("R9 final drain", {22'h0, tx_count, rx_count}, 32'h0);

    summary();
  end

endmodule